// File: doc/BRIEF.md
# Up/Down Compare Timer

A free-running counter that climbs from zero to a programmable period value and then falls back to zero, over and over. The count goes up by one per clock until it reaches the period, then down by one per clock until it reaches zero. A full cycle therefore takes twice the period in clocks. The block has several compare channels. Each channel owns a compare value and a three-bit output mode, and drives one output pin.

A channel's pin reacts when the count equals the channel's compare value, whether the count is rising or falling. In some modes it also reacts when the count equals the period value. A sticky per-channel match flag records compare hits, and a sticky overflow flag records each return of the count to zero. Software programs the block through a single synchronous write port. Writing ones to a clear register resets the flags.

Top module: `updown_timer`

## Requirements
- R1: After reset, `count` is 0, `dir_down` is 0, and every output pin, match flag and the overflow flag is 0.
- R2: Writes are taken on the rising clock edge while `wr_en` is 1. The register map is as follows. Address 0 holds the period. Address 1 is the clear register. Address 2+2k holds the compare value of channel k. Address 3+2k is the control of channel k: bits [2:0] select the mode and bit 3 is the mode-0 level.
- R3: While the period P is non-zero, the count runs 0,1,…,P,P-1,…,1,0,1,… and the cycle lasts 2P clocks. `dir_down` is 1 on the edge that leaves P and stays 1 until the edge that leaves 0.
- R4: While the period register is 0, the count holds its value and no match is detected.
- R5: `ovf_flag` is set on the edge that loads 0 into the count from a non-zero value. It then stays set until a write to the clear register with bit CNT_W-1 set. A set on the same edge wins over the clear.
- R6: The match flag of channel k is set on the edge after a cycle in which the timer runs and the count equals the channel's compare value. It stays set until a clear-register write with bit k set, and a set on the same edge wins over the clear.
- R7: A pin changes on the clock edge that ends the cycle in which the match is seen, not earlier.
- R8: On a channel match, mode 1 sets the pin, mode 4 toggles it and mode 5 clears it. These modes ignore the period match.
- R9: On a channel match, mode 2 toggles the pin, mode 3 sets it, mode 6 toggles it and mode 7 clears it. On a period match, modes 2 and 3 clear the pin and modes 6 and 7 set it. When both matches fall in the same cycle, the period action wins.
- R10: In mode 0 the pin takes the value of the channel's level bit on each clock edge.
- R11: Moving from one non-zero mode to another by way of mode 7 never makes the pin take the level bit. With no match, the pin keeps its level through the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | CNT_W | Write data |
| count | output | CNT_W | Current timer count |
| dir_down | output | 1 | 1 while the count is falling |
| ovf_flag | output | 1 | Sticky return-to-zero flag |
| match_flag | output | NCH | Sticky compare-match flags |
| out_pin | output | NCH | Channel output pins |

## Verification
The channels are run with several mixes of modes and compare values. These include a compare value of 0, a value equal to the period, and values in the middle of the range. The zero and period cases show whether a hit at a turning point happens once or twice per cycle, and whether the period action wins over the channel action. Mid-range values show the separate rising and falling hits that toggle modes depend on. The sweep then covers the shortest period of one, a frozen timer for the clear register, and a mode-7 transition with the level bit held opposite to the pin, which exposes any pass through mode 0.

// File: rtl/updown_timer.sv
module updown_timer #(
  parameter int CNT_W = 16,
  parameter int NCH = 3,
  localparam int AW = $clog2(2*NCH+2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             ovf_flag,
  output logic [NCH-1:0]   match_flag,
  output logic [NCH-1:0]   out_pin
);
  localparam logic [AW-1:0] A_PER = AW'(0);
  localparam logic [AW-1:0] A_CLR = AW'(1);

  logic [CNT_W-1:0] period;
  logic [NCH-1:0][CNT_W-1:0] ccr_v;
  logic [NCH-1:0][2:0] mode_v;
  logic [NCH-1:0] lvl_v;
  logic running, at_top, per_eq, clr_wr, ovf_set;

  assign running = |period;
  assign at_top  = count >= period;
  assign per_eq  = running && (count == period);
  assign clr_wr  = wr_en && (wr_addr == A_CLR);
  assign ovf_set = running && (count == CNT_W'(1)) && (dir_down || at_top);

  always_ff @(posedge clk) begin
    if (!rst_n) period <= '0;
    else if (wr_en && wr_addr == A_PER) period <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      dir_down <= 1'b0;
    end else if (running) begin
      if (!dir_down) begin
        if (at_top) begin
          dir_down <= 1'b1;
          count <= count - 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end else if (count == '0) begin
        dir_down <= 1'b0;
        count <= count + 1'b1;
      end else begin
        count <= count - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_flag <= 1'b0;
    else if (ovf_set) ovf_flag <= 1'b1;
    else if (clr_wr && wr_data[CNT_W-1]) ovf_flag <= 1'b0;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    localparam logic [AW-1:0] A_CMP = AW'(2 + 2*k);
    localparam logic [AW-1:0] A_CTL = AW'(3 + 2*k);
    logic [CNT_W-1:0] cmp;
    logic [2:0] md;
    logic lv, o, flg, eq, nx;

    assign eq = running && (count == cmp);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp <= '0;
        md <= 3'd0;
        lv <= 1'b0;
      end else if (wr_en) begin
        if (wr_addr == A_CMP) cmp <= wr_data;
        if (wr_addr == A_CTL) begin
          md <= wr_data[2:0];
          lv <= wr_data[3];
        end
      end
    end

    always_comb begin
      nx = o;
      if (md == 3'd0) begin
        nx = lv;
      end else begin
        if (eq) begin
          case (md)
            3'd1, 3'd3:       nx = 1'b1;
            3'd2, 3'd4, 3'd6: nx = ~o;
            default:          nx = 1'b0;
          endcase
        end
        if (per_eq) begin
          case (md)
            3'd2, 3'd3: nx = 1'b0;
            3'd6, 3'd7: nx = 1'b1;
            default: ;
          endcase
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        o <= 1'b0;
        flg <= 1'b0;
      end else begin
        o <= nx;
        if (eq) flg <= 1'b1;
        else if (clr_wr && wr_data[k]) flg <= 1'b0;
      end
    end

    assign ccr_v[k]      = cmp;
    assign mode_v[k]     = md;
    assign lvl_v[k]      = lv;
    assign out_pin[k]    = o;
    assign match_flag[k] = flg;
  end
endmodule

// File: rtl/updown_timer_chk.sv
module updown_timer_chk #(
  parameter int CNT_W = 16,
  parameter int NCH = 3
) (
  input logic clk,
  input logic rst_n,
  input logic [CNT_W-1:0] count,
  input logic dir_down,
  input logic ovf_flag,
  input logic [NCH-1:0] out_pin,
  input logic [CNT_W-1:0] period,
  input logic [NCH-1:0][CNT_W-1:0] ccr_v,
  input logic [NCH-1:0][2:0] mode_v,
  input logic [NCH-1:0] lvl_v
);
  AST_COUNT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (period != '0 && !dir_down && count < period) |=> (count == $past(count) + 1'b1)); // R3
  AST_TURN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (period != '0 && !dir_down && count >= period) |=> dir_down); // R3
  AST_TURN_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (period != '0 && dir_down && count == '0) |=> (!dir_down && count == CNT_W'(1))); // R3
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) |=> $stable(count)); // R4
  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (count == '0)); // R5

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    AST_MODE0_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_v[k] == 3'd0) |=> (out_pin[k] == $past(lvl_v[k]))); // R10
    AST_MODE1_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_v[k] == 3'd1 && period != '0 && count == ccr_v[k]) |=> out_pin[k]); // R8
    AST_MODE5_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_v[k] == 3'd5 && period != '0 && count == ccr_v[k]) |=> !out_pin[k]); // R8
    AST_MODE3_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_v[k] == 3'd3 && period != '0 && count == period) |=> !out_pin[k]); // R9
    AST_MODE7_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_v[k] == 3'd7 && period != '0 && count == period) |=> out_pin[k]); // R9
  end
endmodule

bind updown_timer updown_timer_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .dir_down(dir_down),
  .ovf_flag(ovf_flag), .out_pin(out_pin), .period(period),
  .ccr_v(ccr_v), .mode_v(mode_v), .lvl_v(lvl_v)
);

// File: tb/updown_timer_bench.sv
module updown_timer_bench;
  localparam int CLK_P = 10;
  localparam int NCH = 3;
  localparam int CNT_W = 16;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [CNT_W-1:0] count;
  logic dir_down, ovf_flag;
  logic [NCH-1:0] match_flag, out_pin;

  updown_timer u_updown_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .dir_down(dir_down), .ovf_flag(ovf_flag),
    .match_flag(match_flag), .out_pin(out_pin)
  );

  always #(CLK_P/2) clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 0;
  bit cmp_on = 0;
  int max_cnt = 0;

  int m_cnt, m_dir, m_per, m_ovf;
  int m_ccr[NCH], m_md[NCH], m_lv[NCH], m_out[NCH], m_flg[NCH];

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string mtag(input int m);
    if (m == 0) return "R10";
    if (m == 1 || m == 4 || m == 5) return "R8";
    return "R9";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_dir = 0; m_per = 0; m_ovf = 0;
      for (int k = 0; k < NCH; k++) begin
        m_ccr[k] = 0; m_md[k] = 0; m_lv[k] = 0; m_out[k] = 0; m_flg[k] = 0;
      end
    end else begin
      bit run, top_hit, clr;
      int n, d;
      run = (m_per != 0);
      top_hit = run && (m_cnt == m_per);
      clr = wr_en && (wr_addr == 1);
      for (int k = 0; k < NCH; k++) begin
        bit hit;
        hit = run && (m_cnt == m_ccr[k]);
        if (m_md[k] == 0) m_out[k] = m_lv[k];
        else begin
          if (hit) begin
            if (m_md[k] == 1 || m_md[k] == 3) m_out[k] = 1;
            else if (m_md[k] == 5 || m_md[k] == 7) m_out[k] = 0;
            else m_out[k] = 1 - m_out[k];
          end
          if (top_hit) begin
            if (m_md[k] == 2 || m_md[k] == 3) m_out[k] = 0;
            if (m_md[k] == 6 || m_md[k] == 7) m_out[k] = 1;
          end
        end
        if (hit) m_flg[k] = 1;
        else if (clr && wr_data[k]) m_flg[k] = 0;
      end
      n = m_cnt; d = m_dir;
      if (run) begin
        if (m_dir == 0 && m_cnt >= m_per) begin d = 1; n = m_cnt - 1; end
        else if (m_dir == 0) n = m_cnt + 1;
        else if (m_cnt == 0) begin d = 0; n = 1; end
        else n = m_cnt - 1;
      end
      if (run && n == 0 && m_cnt != 0) m_ovf = 1;
      else if (clr && wr_data[CNT_W-1]) m_ovf = 0;
      m_cnt = n; m_dir = d;
      if (wr_en) begin
        if (wr_addr == 0) m_per = wr_data;
        for (int k = 0; k < NCH; k++) begin
          if (wr_addr == 2 + 2*k) m_ccr[k] = wr_data;
          if (wr_addr == 3 + 2*k) begin m_md[k] = wr_data[2:0]; m_lv[k] = wr_data[3]; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk("R3 count", int'(count), m_cnt);
      chk("R3 dir_down", int'(dir_down), m_dir);
      chk("R5 ovf_flag", int'(ovf_flag), m_ovf);
      for (int k = 0; k < NCH; k++) begin
        chk("R6 match_flag", int'(match_flag[k]), m_flg[k]);
        chk({mtag(m_md[k]), " out_pin"}, int'(out_pin[k]), m_out[k]);
      end
      if (int'(count) > max_cnt) max_cnt = int'(count);
    end
  end

  task automatic wr(input int a, input int v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = CNT_W'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", int'(count), 0);
    chk("R1 dir_down", int'(dir_down), 0);
    chk("R1 ovf_flag", int'(ovf_flag), 0);
    chk("R1 match_flag", int'(match_flag), 0);
    chk("R1 out_pin", int'(out_pin), 0);
    cmp_on = 1;

    wr(2, 3); wr(3, 1);
    wr(4, 2); wr(5, 4);
    wr(6, 6); wr(7, 5);
    wr(0, 6);
    do @(negedge clk); while (count != 16'd3);
    chk("R7 pin before edge", int'(out_pin[0]), 0);
    @(negedge clk);
    chk("R7 pin after edge", int'(out_pin[0]), 1);
    idle(24);
    chk("R2 peak equals written period", max_cnt, 6);

    wr(3, 2); wr(5, 3); wr(7, 6);
    idle(26);
    wr(2, 0); wr(3, 7); wr(4, 6); wr(5, 8); wr(6, 4); wr(7, 4);
    idle(26);
    wr(2, 6); wr(3, 6); wr(4, 1); wr(5, 2); wr(6, 6); wr(7, 3);
    idle(26);
    wr(0, 1);
    idle(8);
    wr(0, 5); wr(3, 4); wr(5, 5); wr(7, 1);
    idle(22);

    wr(0, 0);
    idle(2);
    begin
      int held;
      held = int'(count);
      idle(5);
      chk("R4 frozen count", int'(count), held);
    end
    wr(1, 32'h0000_8007);
    idle(1);
    chk("R6 flags cleared", int'(match_flag), 0);
    chk("R5 overflow cleared", int'(ovf_flag), 0);

    wr(3, 0);
    idle(2);
    chk("R10 level low", int'(out_pin[0]), 0);
    wr(3, 8 | 5);
    chk("R11 pin in mode 5", int'(out_pin[0]), 0);
    wr(3, 8 | 7);
    chk("R11 pin in mode 7", int'(out_pin[0]), 0);
    wr(3, 8 | 4);
    idle(3);
    chk("R11 pin after switch", int'(out_pin[0]), 0);
    wr(3, 8);
    idle(1);
    chk("R10 level high", int'(out_pin[0]), 1);
    idle(2);
    finish_run();
  end
endmodule